// File: doc/BRIEF.md
# Twin-Predicated Element Move Sequencer

This block steps through a vectorised register-to-register move in which the source side and the destination side each carry their own predicate mask and their own zeroing flag. A pulse on `start` captures the element count and both sides' settings. From the next cycle the sequencer issues one transfer per cycle. Each transfer is a pair of element indices, one to read and one to write, plus a flag that forces the written data to zero. The register file and the data path sit outside the block. They read `src_idx`, write to `dst_idx` when `wr_en` is high, and substitute zero for the data when `zero_data` is high.

The two indices move independently. With zeroing off, a vector side passes over its masked-out positions. Because each side does this separately, the move packs sparse source elements into dense destination slots, or spreads dense elements out into sparse ones. With zeroing on, a masked-out position is not passed over; it takes part in the transfer with zero data. A scalar side stays at element 0. The sequencer has three states. `MV_IDLE` waits for `start`. `MV_RUN` issues transfers. `MV_DONE` pulses `done` for one cycle and returns to `MV_IDLE`. The transitions are: IDLE to RUN on start, RUN to DONE on exhaustion or after a scalar-destination write, and DONE to IDLE unconditionally.

Top module: `mvseq_top`

## Requirements
- R1: After reset, `wr_en`, `zero_data` and `done` are low. While in `MV_IDLE`, a `start` pulse captures `vl`, `src_vec`, `dst_vec`, both masks and both zeroing flags. A `start`, or any change to those inputs, while a move is in progress has no effect on that move.
- R2: When the source is a vector and source zeroing is off, each transfer reads the lowest source position at or above the current source index whose source mask bit is 1. Bit k of a mask belongs to element k.
- R3: When the destination is a vector and destination zeroing is off, each transfer writes the lowest destination position at or above the current destination index whose destination mask bit is 1. Masked-out destination elements are never written.
- R4: When the source is a vector and source zeroing is on, a source position whose mask bit is 0 is not passed over. Its transfer is issued with `zero_data` high.
- R5: When the destination is a vector and destination zeroing is on, a destination position whose mask bit is 0 is not passed over. It is written with `zero_data` high.
- R6: When both sides zero, `zero_data` is high on a transfer whenever either the source bit or the destination bit at its index is 0. It is low when both bits are 1.
- R7: The move ends, with no further transfer, as soon as the source index or the destination index reaches `vl`. When `vl` is 0, no transfer is issued.
- R8: When the source is scalar, every transfer reads element 0.
- R9: When the destination is scalar, the move ends after its first write, which goes to element 0.
- R10: A side that is scalar ignores its own mask and zeroing flag.
- R11: The first transfer appears in the cycle after `start` is sampled. After each transfer, both indices advance by one. A vector move therefore issues one transfer per cycle with no gaps.
- R12: `done` is a single-cycle pulse and never coincides with `wr_en`. For a vector destination with n transfers, it is high in the (n+2)-th cycle after the start edge. For a scalar destination, it is high in the 2nd cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a move (sampled in idle only) |
| vl | input | $clog2(MAX_VL)+1 | Element count, 0 to MAX_VL |
| src_vec | input | 1 | Source is a vector (1) or scalar (0) |
| dst_vec | input | 1 | Destination is a vector (1) or scalar (0) |
| src_mask | input | MAX_VL | Source predicate, bit k for element k |
| dst_mask | input | MAX_VL | Destination predicate, bit k for element k |
| src_zero | input | 1 | Source zeroing mode |
| dst_zero | input | 1 | Destination zeroing mode |
| src_idx | output | $clog2(MAX_VL) | Element to read this cycle |
| dst_idx | output | $clog2(MAX_VL) | Element to write this cycle |
| wr_en | output | 1 | A transfer is issued this cycle |
| zero_data | output | 1 | Write zero instead of the read data |
| done | output | 1 | One-cycle end-of-move pulse |

## Verification
All results are combinational functions of registered state, so they are valid for a whole cycle and are sampled on the falling edge. The bench counts falling edges from the start edge. Transfer k of a move is due at count k. `done` is due at count n+2 for a vector destination and at count 2 for a scalar one. The scoreboard pops one expected transfer per `wr_en`, and checks the `done` count and an empty queue when `done` arrives.

// File: rtl/mvseq_pkg.sv
package mvseq_pkg;
    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_RUN  = 2'd1,
        MV_DONE = 2'd2
    } mv_state_e;
endpackage

// File: rtl/mvseq_skip.sv
module mvseq_skip #(
    parameter int MAX_VL = 16,
    localparam int CW = $clog2(MAX_VL) + 1
) (
    input  logic [CW-1:0]     cur,
    input  logic [CW-1:0]     vl,
    input  logic [MAX_VL-1:0] mask,
    input  logic              skip_en,
    output logic [CW-1:0]     nxt,
    output logic              at_end
);
    // Lowest enabled position at or above cur; vl when none remains.
    always_comb begin
        nxt = cur;
        if (skip_en) begin
            nxt = vl;
            for (int k = MAX_VL - 1; k >= 0; k--) begin
                if (CW'(k) >= cur && CW'(k) < vl && mask[k])
                    nxt = CW'(k);
            end
        end
        at_end = (nxt >= vl);
    end
endmodule

// File: rtl/mvseq_zero.sv
module mvseq_zero (
    input  logic src_bit,
    input  logic dst_bit,
    input  logic src_zen,
    input  logic dst_zen,
    output logic force_zero
);
    always_comb force_zero = (src_zen && !src_bit) || (dst_zen && !dst_bit);
endmodule

// File: rtl/mvseq_top.sv
module mvseq_top #(
    parameter int MAX_VL = 16,
    localparam int IW = $clog2(MAX_VL),
    localparam int CW = IW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CW-1:0]     vl,
    input  logic              src_vec,
    input  logic              dst_vec,
    input  logic [MAX_VL-1:0] src_mask,
    input  logic [MAX_VL-1:0] dst_mask,
    input  logic              src_zero,
    input  logic              dst_zero,
    output logic [IW-1:0]     src_idx,
    output logic [IW-1:0]     dst_idx,
    output logic              wr_en,
    output logic              zero_data,
    output logic              done
);
    import mvseq_pkg::*;

    mv_state_e         state, state_nx;
    logic [CW-1:0]     vl_q, si_q, di_q;
    logic [MAX_VL-1:0] smask_q, dmask_q;
    logic              svec_q, dvec_q, sz_q, dz_q;

    logic [CW-1:0] s_nxt, d_nxt;
    logic          s_end, d_end, fin, xfer, fz;

    mvseq_skip #(.MAX_VL(MAX_VL)) u_src_skip (
        .cur(si_q), .vl(vl_q), .mask(smask_q),
        .skip_en(svec_q && !sz_q), .nxt(s_nxt), .at_end(s_end)
    );

    mvseq_skip #(.MAX_VL(MAX_VL)) u_dst_skip (
        .cur(di_q), .vl(vl_q), .mask(dmask_q),
        .skip_en(dvec_q && !dz_q), .nxt(d_nxt), .at_end(d_end)
    );

    mvseq_zero u_zero (
        .src_bit(smask_q[s_nxt[IW-1:0]]), .dst_bit(dmask_q[d_nxt[IW-1:0]]),
        .src_zen(svec_q && sz_q), .dst_zen(dvec_q && dz_q),
        .force_zero(fz)
    );

    assign fin  = s_end || d_end;
    assign xfer = (state == MV_RUN) && !fin;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            MV_IDLE: if (start) state_nx = MV_RUN;
            MV_RUN:  if (fin || !dvec_q) state_nx = MV_DONE;
            MV_DONE: state_nx = MV_IDLE;
            default: state_nx = MV_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MV_IDLE;
        else        state <= state_nx;
    end

    // Captured configuration and running indices
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q <= '0; si_q <= '0; di_q <= '0;
            smask_q <= '0; dmask_q <= '0;
            svec_q <= 1'b0; dvec_q <= 1'b0; sz_q <= 1'b0; dz_q <= 1'b0;
        end else if (state == MV_IDLE && start) begin
            vl_q <= vl; si_q <= '0; di_q <= '0;
            smask_q <= src_mask; dmask_q <= dst_mask;
            svec_q <= src_vec; dvec_q <= dst_vec;
            sz_q <= src_zero; dz_q <= dst_zero;
        end else if (xfer) begin
            si_q <= svec_q ? s_nxt + CW'(1) : '0;
            di_q <= d_nxt + CW'(1);
        end
    end

    // Outputs
    always_comb begin
        wr_en     = xfer;
        zero_data = xfer && fz;
        src_idx   = xfer ? s_nxt[IW-1:0] : '0;
        dst_idx   = xfer ? d_nxt[IW-1:0] : '0;
        done      = (state == MV_DONE);
    end

    assert_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (CW'(src_idx) < vl_q && CW'(dst_idx) < vl_q));
    assert_src_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && svec_q && !sz_q) |-> smask_q[src_idx]);
    assert_dst_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dvec_q && !dz_q) |-> dmask_q[dst_idx]);
    assert_scalar_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !svec_q) |-> (src_idx == '0));
    assert_dst_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (dst_idx > $past(dst_idx)));
    assert_zero_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        zero_data |-> (wr_en && (sz_q || dz_q)));
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && wr_en));
    assert_scalar_dst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dvec_q) |=> done);
endmodule

// File: tb/mvseq_top_tb_top.sv
module mvseq_top_tb_top;
    localparam int MAXV = 16;
    localparam int IW = $clog2(MAXV);
    localparam int CW = IW + 1;

    typedef struct packed {
        logic [IW-1:0] s;
        logic [IW-1:0] d;
        logic          z;
    } xfer_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] vl = '0;
    logic src_vec = 1'b0, dst_vec = 1'b0, src_zero = 1'b0, dst_zero = 1'b0;
    logic [MAXV-1:0] src_mask = '0, dst_mask = '0;
    logic [IW-1:0] src_idx, dst_idx;
    logic wr_en, zero_data, done;

    always #10 clk = ~clk;

    mvseq_top #(.MAX_VL(MAXV)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
        .src_vec(src_vec), .dst_vec(dst_vec),
        .src_mask(src_mask), .dst_mask(dst_mask),
        .src_zero(src_zero), .dst_zero(dst_zero),
        .src_idx(src_idx), .dst_idx(dst_idx),
        .wr_en(wr_en), .zero_data(zero_data), .done(done)
    );

    int n_chk = 0, n_fail = 0;
    xfer_t exp_q[$];
    logic [7:0] src_arr[MAXV];
    logic [7:0] dut_dst[MAXV];
    logic [7:0] exp_dst[MAXV];
    int  exp_cyc = 0, cyc = 0;
    bit  active = 0, fin_flag = 0;
    string cur_tag = "R1";

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard on every transfer, checks timing at done
    always @(negedge clk) begin
        if (active) begin
            cyc++;
            if (wr_en) begin
                if (exp_q.size() == 0) begin
                    chk(0, cur_tag, "unexpected transfer dst_idx", int'(dst_idx), -1);
                end else begin
                    xfer_t e;
                    e = exp_q.pop_front();
                    chk(src_idx == e.s, cur_tag, "src_idx", int'(src_idx), int'(e.s));
                    chk(dst_idx == e.d, cur_tag, "dst_idx", int'(dst_idx), int'(e.d));
                    chk(zero_data == e.z, cur_tag, "zero_data", int'(zero_data), int'(e.z));
                end
                dut_dst[dst_idx] = zero_data ? 8'h00 : src_arr[src_idx];
            end
            if (done) begin
                chk(!wr_en, "R12", "wr_en with done", int'(wr_en), 0);
                chk(cyc == exp_cyc, "R12", "done cycle", cyc, exp_cyc);
                chk(exp_q.size() == 0, cur_tag, "missing transfers", exp_q.size(), 0);
                for (int k = 0; k < MAXV; k++)
                    if (dut_dst[k] != exp_dst[k])
                        chk(0, cur_tag, $sformatf("dst element %0d", k),
                            int'(dut_dst[k]), int'(exp_dst[k]));
                n_chk++;
                active = 0;
                fin_flag = 1;
            end
        end else if (rst_n && (wr_en || done)) begin
            chk(0, "R1", "activity while idle", int'({wr_en, done}), 0);
        end
    end

    // Driver: builds the expected transfer list from the requirements, then launches
    task automatic run_case(string tag, int v, bit sv, bit dv,
                            logic [MAXV-1:0] sm, logic [MAXV-1:0] dm,
                            bit sz, bit dz, bit poke);
        int i = 0, j = 0, cnt = 0;
        exp_q.delete();
        for (int k = 0; k < MAXV; k++) begin
            src_arr[k] = 8'h10 + 8'(k);
            exp_dst[k] = 8'hE0 + 8'(k);
            dut_dst[k] = 8'hE0 + 8'(k);
        end
        forever begin
            xfer_t e;
            if (sv && !sz) while (i < v && !sm[i]) i++;          // R2
            if (dv && !dz) while (j < v && !dm[j]) j++;          // R3
            if (i >= v || j >= v) break;                         // R7
            e.s = IW'(i);
            e.d = IW'(j);
            e.z = (sv && sz && !sm[i]) || (dv && dz && !dm[j]);  // R4 R5 R6 R10
            exp_q.push_back(e);
            exp_dst[j] = e.z ? 8'h00 : src_arr[i];
            cnt++;
            if (!dv) break;                                      // R9
            i = sv ? i + 1 : 0;                                  // R8 R11
            j++;
        end
        exp_cyc = dv ? cnt + 2 : 2;                              // R12
        @(negedge clk);
        vl = CW'(v); src_vec = sv; dst_vec = dv;
        src_mask = sm; dst_mask = dm; src_zero = sz; dst_zero = dz;
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        cur_tag = tag;
        cyc = 0;
        fin_flag = 0;
        active = 1;
        if (poke) begin
            // R1: start and changed inputs during a move must not disturb it
            repeat (2) @(posedge clk);
            #1;
            start = 1'b1; src_mask = ~sm; dst_mask = ~dm; vl = CW'(2);
            src_zero = ~sz; dst_zero = ~dz;
            @(posedge clk);
            #1;
            start = 1'b0;
        end
        wait (fin_flag);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!wr_en, "R1", "reset wr_en", int'(wr_en), 0);
        chk(!done, "R1", "reset done", int'(done), 0);
        chk(!zero_data, "R1", "reset zero_data", int'(zero_data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case("R11", 5, 1, 1, 16'hFFFF, 16'hFFFF, 0, 0, 0);
        run_case("R2",  8, 1, 1, 16'b1011_0010, 16'hFFFF, 0, 0, 0);
        run_case("R3",  8, 1, 1, 16'hFFFF, 16'b0110_1001, 0, 0, 0);
        run_case("R4",  6, 1, 1, 16'b0010_1101, 16'hFFFF, 1, 0, 0);
        run_case("R5",  6, 1, 1, 16'hFFFF, 16'b0011_0110, 0, 1, 0);
        run_case("R6",  7, 1, 1, 16'b0101_0011, 16'b0011_0101, 1, 1, 0);
        run_case("R7",  0, 1, 1, 16'hFFFF, 16'hFFFF, 0, 0, 0);
        run_case("R7",  8, 1, 1, 16'b0000_0101, 16'hFFFF, 0, 0, 0);
        run_case("R7",  8, 1, 1, 16'hFFFF, 16'b0100_0001, 0, 0, 0);
        run_case("R8",  6, 0, 1, 16'h0000, 16'b0011_1010, 0, 0, 0);
        run_case("R9",  8, 1, 0, 16'b0000_0100, 16'h0000, 0, 0, 0);
        run_case("R10", 4, 0, 1, 16'h0000, 16'hFFFF, 1, 0, 0);
        run_case("R10", 4, 1, 0, 16'hFFFF, 16'h0000, 0, 1, 0);
        run_case("R1",  8, 1, 1, 16'hFFFF, 16'hFFFF, 0, 0, 1);
        run_case("R12", 16, 1, 1, 16'hFFFF, 16'hFFFF, 0, 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule